// File: doc/BRIEF.md
# Frame CRC Generate/Check Sequencer

This block sits in a transmit path that carries 32-bit words, each marked as data or as an ordered set. It runs a CRC-32 over the payload of each frame, meaning the data words between the ordered set that opens the frame and the end-of-frame ordered set that closes it. A per-word select picks one of two uses. In generate mode the block appends the CRC itself: when an end-of-frame arrives it sends the CRC word first and holds the end-of-frame back by one cycle, discarding whatever is on the inputs in the cycle the held end-of-frame goes out. In check mode the last payload word is taken to be a CRC that was already computed, and a mismatch raises a one-cycle error pulse.

Any ordered set restarts the CRC. A frame that carried a parity error (flagged on an input) or that failed its CRC check has its normal or terminate end-of-frame rewritten to the normal-invalid code before it leaves. A raw input lets any word through untouched, past all of this logic. Every output is registered, one cycle behind its input.

Top module: `fcs_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after, `out_word`, `out_os` and `crc_err` are all zero.
- R2: A data word (`in_os`=0, `in_raw`=0, not in a stall cycle) comes out on `out_word` one cycle later with `out_os`=0.
- R3: The CRC is computed MSB-first, not reflected, with polynomial 0x04C11DB7 and an accumulator seeded to all ones. In generate mode (`in_gen`=1) an end-of-frame input makes the next output the bitwise complement of the accumulator over that frame's payload, with `out_os`=0. The end-of-frame itself comes out the cycle after that, with `out_os`=1.
- R4: In the cycle in which a held end-of-frame is being emitted, every input is ignored. The word is not output, does not reseed the CRC, and does not start another insertion.
- R5: In check mode (`in_gen`=0) the last payload word before the end-of-frame is the received CRC. If it differs from the complement of the CRC over the earlier payload words, or if the frame has no payload word at all, `crc_err` is high for exactly the one cycle after the end-of-frame appears on `out_word`. Otherwise `crc_err` stays low.
- R6: `crc_err` is never raised by a generate-mode end-of-frame or by raw words.
- R7: Any ordered set, and not only a start-of-frame, reseeds the CRC and clears the frame's error history.
- R8: An ordered set is an end-of-frame when its top byte (bits 31:24) is one of the four codes: normal 0xE1, terminate 0xE2, abort 0xE3 or normal-invalid 0xE4. For a bad frame, the top byte of a normal or terminate end-of-frame becomes 0xE4 and bits 23:0 are kept. Abort and normal-invalid end-of-frames pass unchanged.
- R9: A frame is bad if `in_perr` was high on any of its payload words or on its end-of-frame word (in either mode), or if its CRC check failed (check mode). A parity error in one frame does not affect the next frame.
- R10: With `in_raw`=1 (outside a stall cycle), `in_word` and `in_os` come out unchanged one cycle later, and the CRC state is unaffected, so a raw word inside a frame is left out of that frame's CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 32 | Input word |
| in_os | input | 1 | Input word is an ordered set |
| in_gen | input | 1 | 1 = generate CRC, 0 = check CRC |
| in_raw | input | 1 | Pass the word through, bypassing CRC logic |
| in_perr | input | 1 | Parity error seen on this word |
| out_word | output | 32 | Output word |
| out_os | output | 1 | Output word is an ordered set |
| crc_err | output | 1 | CRC check failure pulse |

## Verification
The checker watches the properties that hold cycle by cycle:
- One-cycle pass-through of data and raw words.
- The stall cycle that follows a generate-mode end-of-frame, which always emits an ordered set and never stalls again.
- `crc_err` appearing only one cycle after a check-mode end-of-frame has gone out.

Only the bench scenarios can show that the inserted and compared CRC values are right, and that parity history and reseeding by non-start ordered sets select the correct end-of-frame rewrite. The bench sweeps frame lengths, parity error positions, end-of-frame codes and both modes against a CRC computed arithmetically in the bench.

// File: rtl/fcs_seq_pkg.sv
package fcs_seq_pkg;
  localparam int unsigned CRC_W = 32;

  typedef logic [CRC_W-1:0] crc_word_t;

  typedef enum logic {
    ST_PASS,
    ST_EOF_HELD
  } seq_state_t;

  // One word folded into the accumulator, MSB first, non-reflected.
  function automatic crc_word_t crc_fold(input crc_word_t acc,
                                         input crc_word_t din,
                                         input crc_word_t poly);
    crc_word_t r;
    logic      fb;
    r = acc;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ din[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step
  import fcs_seq_pkg::*;
#(
  parameter crc_word_t POLY = 32'h04C1_1DB7
) (
  input  crc_word_t acc_i,
  input  crc_word_t din_i,
  output crc_word_t acc_o
);
  assign acc_o = crc_fold(acc_i, din_i, POLY);
endmodule

// File: rtl/fcs_eof_rewrite.sv
module fcs_eof_rewrite
  import fcs_seq_pkg::*;
#(
  parameter int unsigned          TAG_W   = 8,
  parameter logic [TAG_W-1:0]     CODE_N  = 8'hE1,
  parameter logic [TAG_W-1:0]     CODE_T  = 8'hE2,
  parameter logic [TAG_W-1:0]     CODE_A  = 8'hE3,
  parameter logic [TAG_W-1:0]     CODE_NI = 8'hE4
) (
  input  crc_word_t word_i,
  input  logic      bad_i,
  output logic      is_eof_o,
  output crc_word_t word_o
);
  localparam int unsigned TAG_LSB = CRC_W - TAG_W;

  logic [TAG_W-1:0] tag;
  logic             demotable;

  assign tag       = word_i[CRC_W-1:TAG_LSB];
  assign demotable = (tag == CODE_N) || (tag == CODE_T);
  assign is_eof_o  = demotable || (tag == CODE_A) || (tag == CODE_NI);
  assign word_o    = (bad_i && demotable) ? {CODE_NI, word_i[TAG_LSB-1:0]} : word_i;
endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer
  import fcs_seq_pkg::*;
#(
  parameter logic [31:0]      CRC_POLY = 32'h04C1_1DB7,
  parameter logic [31:0]      CRC_SEED = 32'hFFFF_FFFF,
  parameter int unsigned      TAG_W    = 8,
  parameter logic [TAG_W-1:0] EOF_N    = 8'hE1,
  parameter logic [TAG_W-1:0] EOF_T    = 8'hE2,
  parameter logic [TAG_W-1:0] EOF_A    = 8'hE3,
  parameter logic [TAG_W-1:0] EOF_NI   = 8'hE4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] in_word,
  input  logic        in_os,
  input  logic        in_gen,
  input  logic        in_raw,
  input  logic        in_perr,
  output logic [31:0] out_word,
  output logic        out_os,
  output logic        crc_err
);
  seq_state_t st_q;
  crc_word_t  acc_q, prev_q, held_q;
  logic       prev_vld_q, bad_q, err_pend_q;

  crc_word_t  fold_in, fold_out, eof_out;
  logic       stall_w, take_w, in_eof, mismatch, bad_now;

  assign stall_w  = (st_q == ST_EOF_HELD);
  assign take_w   = !stall_w && !in_raw;
  // Generate mode folds the live word; check mode folds the delayed one,
  // so the final payload word (the received CRC) is never folded.
  assign fold_in  = in_gen ? in_word : prev_q;
  assign mismatch = !prev_vld_q || (prev_q != ~acc_q);
  assign bad_now  = bad_q || in_perr || (!in_gen && mismatch);

  fcs_crc_step #(.POLY(CRC_POLY)) step_i (
    .acc_i (acc_q),
    .din_i (fold_in),
    .acc_o (fold_out)
  );

  fcs_eof_rewrite #(
    .TAG_W  (TAG_W),
    .CODE_N (EOF_N),
    .CODE_T (EOF_T),
    .CODE_A (EOF_A),
    .CODE_NI(EOF_NI)
  ) rewrite_i (
    .word_i  (in_word),
    .bad_i   (bad_now),
    .is_eof_o(in_eof),
    .word_o  (eof_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_PASS;
      acc_q      <= CRC_SEED;
      prev_q     <= '0;
      held_q     <= '0;
      prev_vld_q <= 1'b0;
      bad_q      <= 1'b0;
      err_pend_q <= 1'b0;
      out_word   <= '0;
      out_os     <= 1'b0;
      crc_err    <= 1'b0;
    end else begin
      crc_err    <= err_pend_q;
      err_pend_q <= 1'b0;
      if (stall_w) begin
        out_word <= held_q;
        out_os   <= 1'b1;
        st_q     <= ST_PASS;
      end else if (in_raw) begin
        out_word <= in_word;
        out_os   <= in_os;
      end else if (in_os) begin
        acc_q      <= CRC_SEED;
        bad_q      <= 1'b0;
        prev_vld_q <= 1'b0;
        if (in_eof && in_gen) begin
          out_word <= ~acc_q;
          out_os   <= 1'b0;
          held_q   <= eof_out;
          st_q     <= ST_EOF_HELD;
        end else if (in_eof) begin
          out_word   <= eof_out;
          out_os     <= 1'b1;
          err_pend_q <= mismatch;
        end else begin
          out_word <= in_word;
          out_os   <= 1'b1;
        end
      end else begin
        out_word <= in_word;
        out_os   <= 1'b0;
        bad_q    <= bad_q || in_perr;
        if (in_gen || prev_vld_q) acc_q <= fold_out;
        if (!in_gen) begin
          prev_q     <= in_word;
          prev_vld_q <= 1'b1;
        end
      end
    end
  end

  logic unused_take;
  assign unused_take = take_w;
endmodule

// File: rtl/fcs_sequencer_chk.sv
module fcs_sequencer_chk #(
  parameter int unsigned      TAG_W  = 8,
  parameter logic [TAG_W-1:0] EOF_N  = 8'hE1,
  parameter logic [TAG_W-1:0] EOF_T  = 8'hE2,
  parameter logic [TAG_W-1:0] EOF_A  = 8'hE3,
  parameter logic [TAG_W-1:0] EOF_NI = 8'hE4
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] in_word,
  input logic        in_os,
  input logic        in_gen,
  input logic        in_raw,
  input logic [31:0] out_word,
  input logic        out_os,
  input logic        crc_err,
  input logic        stalled
);
  logic [TAG_W-1:0] tag;
  logic             is_eof, take, chk_eof_q;

  assign tag    = in_word[31:32-TAG_W];
  assign is_eof = (tag == EOF_N) || (tag == EOF_T) || (tag == EOF_A) || (tag == EOF_NI);
  assign take   = !stalled && !in_raw;

  always_ff @(posedge clk) begin
    if (rst) chk_eof_q <= 1'b0;
    else     chk_eof_q <= take && in_os && is_eof && !in_gen;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (out_word == '0 && !out_os && !crc_err));

  a_r2_data_pass: assert property (@(posedge clk) disable iff (rst)
    (take && !in_os) |=> (out_word == $past(in_word) && !out_os));

  a_r3_crc_slot: assert property (@(posedge clk) disable iff (rst)
    (take && in_os && is_eof && in_gen) |=> (!out_os && stalled));

  a_r4_stall_emits_eof: assert property (@(posedge clk) disable iff (rst)
    stalled |=> (out_os && !stalled));

  a_r5_err_after_eof: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> $past(out_os));

  a_r6_err_source: assert property (@(posedge clk) disable iff (rst)
    !chk_eof_q |=> !crc_err);

  a_r10_raw_pass: assert property (@(posedge clk) disable iff (rst)
    (!stalled && in_raw) |=> (out_word == $past(in_word) && out_os == $past(in_os)));
endmodule

bind fcs_sequencer fcs_sequencer_chk #(
  .TAG_W (TAG_W),
  .EOF_N (EOF_N),
  .EOF_T (EOF_T),
  .EOF_A (EOF_A),
  .EOF_NI(EOF_NI)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_word (in_word),
  .in_os   (in_os),
  .in_gen  (in_gen),
  .in_raw  (in_raw),
  .out_word(out_word),
  .out_os  (out_os),
  .crc_err (crc_err),
  .stalled (stall_w)
);

// File: tb/fcs_sequencer_tb_top.sv
`timescale 1ns/1ps
module fcs_sequencer_tb_top;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [31:0] SEED = 32'hFFFF_FFFF;
  localparam logic [7:0]  T_N = 8'hE1, T_T = 8'hE2, T_A = 8'hE3, T_NI = 8'hE4;
  localparam logic [7:0]  T_SOF = 8'h5A, T_IDLE = 8'h3C;

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] in_word = '0;
  logic        in_os = 0, in_gen = 0, in_raw = 0, in_perr = 0;
  logic [31:0] out_word;
  logic        out_os, crc_err;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  fcs_sequencer dut_i (
    .clk(clk), .rst(rst), .in_word(in_word), .in_os(in_os), .in_gen(in_gen),
    .in_raw(in_raw), .in_perr(in_perr), .out_word(out_word), .out_os(out_os),
    .crc_err(crc_err)
  );

  function automatic logic [31:0] ref_fold(input logic [31:0] acc, input logic [31:0] w);
    logic [31:0] r = acc;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ w[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_eof(input logic [31:0] w, input bit bad);
    if (bad && (w[31:24] == T_N || w[31:24] == T_T)) return {T_NI, w[23:0]};
    return w;
  endfunction

  function automatic logic [31:0] pw(input int n, input int i);
    logic [31:0] m = 32'h9E37_79B9 * 32'(i + 1);
    return m ^ (32'(n) << 20) ^ 32'h0000_5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] w, input bit os, input bit gen, input bit raw, input bit perr);
    in_word = w; in_os = os; in_gen = gen; in_raw = raw; in_perr = perr;
    @(posedge clk);
    #1;
  endtask

  // perr_at indexes the frame words after the lead ordered set (payload, CRC word in check mode, end-of-frame)
  task automatic do_frame(input bit gen, input int n, input int perr_at, input logic [7:0] eof_tag,
                          input bit bad_crc, input bit omit_crc, input logic [7:0] lead_tag, input int raw_at);
    logic [31:0] acc = SEED;
    logic [31:0] w, ew;
    int k = 0;
    bit pbad = 0, p, mism;
    w = {lead_tag, 24'h00_1234};
    cyc(w, 1, gen, 0, 0);
    chk(out_word == w && out_os, "R7 lead ordered set out", out_word, w);
    for (int i = 0; i < n; i++) begin
      if (i == raw_at) begin
        w = 32'hC0DE_0000 | 32'(i);
        cyc(w, 1, gen, 1, 0);
        chk(out_word == w && out_os, "R10 raw pass", out_word, w);
      end
      w = pw(n, i);
      p = (perr_at == k); pbad |= p; k++;
      cyc(w, 0, gen, 0, p);
      chk(out_word == w && !out_os, "R2 data pass", out_word, w);
      acc = ref_fold(acc, w);
    end
    if (!gen && !omit_crc) begin
      w = ~acc ^ (bad_crc ? 32'h1 : 32'h0);
      p = (perr_at == k); pbad |= p; k++;
      cyc(w, 0, 0, 0, p);
      chk(out_word == w && !out_os, "R2 crc word pass", out_word, w);
    end
    ew = {eof_tag, 24'h00_A5C3};
    p = (perr_at == k); pbad |= p;
    if (gen) begin
      cyc(ew, 1, 1, 0, p);
      chk(out_word == ~acc && !out_os, "R3 inserted crc", out_word, ~acc);
      chk(!crc_err, "R6 no error in generate", {31'b0, crc_err}, 32'h0);
      cyc({T_N, 24'hFF_FFFF}, 1, 1, 0, 1);
      chk(out_word == exp_eof(ew, pbad) && out_os, "R4 R8 R9 held eof", out_word, exp_eof(ew, pbad));
      w = {T_IDLE, 24'h0};
      cyc(w, 1, 1, 0, 0);
      chk(out_word == w && out_os && !crc_err, "R4 R6 after stall", out_word, w);
    end else begin
      mism = bad_crc || omit_crc;
      cyc(ew, 1, 0, 0, p);
      chk(out_word == exp_eof(ew, pbad || mism) && out_os, "R8 R9 check eof", out_word, exp_eof(ew, pbad || mism));
      chk(!crc_err, "R5 no early error", {31'b0, crc_err}, 32'h0);
      cyc({T_IDLE, 24'h0}, 1, 0, 0, 0);
      chk(crc_err == mism, "R5 error pulse", {31'b0, crc_err}, {31'b0, mism});
      cyc({T_IDLE, 24'h0}, 1, 0, 0, 0);
      chk(!crc_err, "R5 single cycle", {31'b0, crc_err}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] tags [4];
    tags[0] = T_N; tags[1] = T_T; tags[2] = T_A; tags[3] = T_NI;
    repeat (3) @(posedge clk);
    #1;
    chk(out_word == '0 && !out_os && !crc_err, "R1 reset state", out_word, 32'h0);
    rst = 0;
    // Sweep: both modes, lengths, every parity position, every end-of-frame code (R3 R5 R8 R9)
    for (int g = 0; g < 2; g++)
      for (int n = 0; n < 5; n++)
        for (int t = 0; t < 4; t++)
          for (int pe = -1; pe < n + 2 - g; pe++)
            do_frame(g[0], n, pe, tags[t], 0, 0, T_SOF, -1);
    // R5 mismatch in check mode
    for (int n = 0; n < 5; n++)
      for (int t = 0; t < 4; t++)
        do_frame(0, n, -1, tags[t], 1, 0, T_SOF, -1);
    // R5 empty frame in check mode counts as a failure
    do_frame(0, 0, -1, T_N, 0, 1, T_SOF, -1);
    // R7 stray words then an idle ordered set reseeds without a start-of-frame
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 3; i++) begin
        cyc(32'h1357_0000 | 32'(i), 0, g[0], 0, 1);
        chk(!out_os, "R7 stray data", out_word, 32'h0);
      end
      do_frame(g[0], 3, -1, T_N, 0, 0, T_IDLE, -1);
    end
    // R10 raw word inside a frame is left out of the CRC
    do_frame(1, 3, -1, T_T, 0, 0, T_SOF, 1);
    do_frame(0, 3, -1, T_N, 0, 0, T_SOF, 2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule